// File: doc/BRIEF.md
# Dual-Polynomial CRC Engine

This block computes cyclic redundancy checks so that the processor does not have to. Through a small register bus, software picks one of two generators: the 16-bit CCITT polynomial or the 32-bit Ethernet polynomial. Picking a generator also restarts the checksum. Software then pushes data through an input register and reads the running checksum back. Every access finishes in one cycle, with no wait states. A data write is folded into the checksum by a combinational parallel update network, so the next cycle already sees the new value.

The configuration word holds more than the polynomial choice. It also selects whether each input byte is bit-reversed, whether the result is bit-reversed across its width, and whether the result is inverted. With these, one engine produces both the non-reflected CCITT checksum and the reflected Ethernet checksum. A byte mode folds in only the low eight bits of each data write, so messages of any byte length can be handled. Word mode folds in all four bytes of the write, most significant byte first.

Top module: `crc_engine`

## Requirements
- R1: After reset, a read at address 0 returns 0x00000000 and a read at address 1 returns 0x0000FFFF.
- R2: A write to address 0 stores the configuration from the write data: bit 0 selects the generator (0 = 16-bit, 1 = 32-bit), bit 1 reverses each input byte, bit 2 reverses the result, bit 3 inverts the result, and bit 4 selects byte mode. A read at address 0 returns these five bits, with zeros above them.
- R3: A write to address 0 loads the checksum state with the seed of the selected generator: 0xFFFF for 16-bit and 0xFFFFFFFF for 32-bit.
- R4: In 16-bit mode the generator is 0x1021, and bits are taken most significant first. With no reversal and no inversion, the nine bytes "123456789" give 0x29B1.
- R5: In 32-bit mode the generator is 0x04C11DB7. With input reversal, result reversal and inversion enabled, "123456789" gives 0xCBF43926.
- R6: In word mode, each data write at address 1 folds in all 32 bits, most significant byte first. The result equals the result of the same four bytes written one at a time in byte mode. In byte mode, data bits 31:8 are ignored.
- R7: In 16-bit mode, a read at address 1 returns the 16-bit result in bits 15:0, with bits 31:16 zero.
- R8: Each write takes effect at the clock edge that samples it. Read data is valid one cycle after the read strobe and holds until the next read. A read issued in the cycle right after a write returns the updated value, and back-to-back data writes are each folded in.
- R9: Reads do not change the checksum. Writes to addresses 2 and 3 change nothing, and reads there return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe, one access per cycle |
| rdEn | input | 1 | Read strobe |
| addr | input | 2 | Register address: 0 configuration, 1 data/result |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |

## Verification
A write is visible in the checksum state after the edge that samples it. Read data appears one edge after the read strobe. So a result can be checked two cycles after the write that produced it, and a read may follow a write directly. The bench drives both strobes at falling edges. For every read, the driver queues the value that a serial bit-by-bit reference model predicts. The monitor notes, at each rising edge, whether a read was sampled, and pops and compares the queued value at the following falling edge. This keeps every comparison in the one cycle where the registered read data is due.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int DATA_W = 32;
  localparam logic [31:0] POLY_NARROW = 32'h0000_1021;
  localparam logic [31:0] POLY_WIDE   = 32'h04C1_1DB7;
  localparam logic [31:0] SEED_NARROW = 32'h0000_FFFF;
  localparam logic [31:0] SEED_WIDE   = 32'hFFFF_FFFF;

  typedef struct packed {
    logic byteMode;
    logic invertOut;
    logic mirrorOut;
    logic mirrorIn;
    logic wideSel;
  } crcCfg_t;

  typedef struct packed {
    logic loadSeed;
    logic seedWide;
    logic absorb;
  } crcStrobe_t;
endpackage

// File: rtl/crc_datapath.sv
module crc_datapath
  import crc_pkg::*;
#(
  parameter int WORD_W = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  crcStrobe_t        strobe,
  input  crcCfg_t           cfg,
  input  logic [WORD_W-1:0] dataIn,
  output logic [31:0]       result
);
  localparam int NBYTES = WORD_W / 8;

  logic [31:0] crcState;
  logic [31:0] nextState;

  function automatic logic [7:0] mirror8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  always_comb begin
    logic [31:0] work;
    logic [7:0]  chunk;
    logic        fb;
    work = crcState;
    for (int b = NBYTES - 1; b >= 0; b--) begin
      if (!cfg.byteMode || b == 0) begin
        chunk = dataIn[b*8 +: 8];
        if (cfg.mirrorIn) chunk = mirror8(chunk);
        for (int i = 7; i >= 0; i--) begin
          if (cfg.wideSel) begin
            fb   = work[31] ^ chunk[i];
            work = {work[30:0], 1'b0} ^ (fb ? POLY_WIDE : 32'h0);
          end else begin
            fb   = work[15] ^ chunk[i];
            work = {16'h0, work[14:0], 1'b0} ^ (fb ? POLY_NARROW : 32'h0);
          end
        end
      end
    end
    nextState = work;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                crcState <= SEED_NARROW;
    else if (strobe.loadSeed)  crcState <= strobe.seedWide ? SEED_WIDE : SEED_NARROW;
    else if (strobe.absorb)    crcState <= nextState;
  end

  always_comb begin
    logic [31:0] raw;
    raw = cfg.wideSel ? crcState : {16'h0, crcState[15:0]};
    if (cfg.mirrorOut) begin
      if (cfg.wideSel) for (int i = 0; i < 32; i++) raw[i] = crcState[31-i];
      else             for (int i = 0; i < 16; i++) raw[i] = crcState[15-i];
    end
    if (cfg.invertOut) raw = raw ^ (cfg.wideSel ? SEED_WIDE : SEED_NARROW);
    result = raw;
  end

  p_seed_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadSeed |=> crcState == ($past(strobe.seedWide) ? SEED_WIDE : SEED_NARROW));

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.loadSeed && !strobe.absorb) |=> $stable(crcState));

  p_narrow_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.absorb && !cfg.wideSel && crcState[31:16] == 16'h0) |=> crcState[31:16] == 16'h0);
endmodule

// File: rtl/crc_control.sv
module crc_control
  import crc_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [31:0]       result,
  output crcStrobe_t        strobe,
  output crcCfg_t           cfgReg,
  output logic [31:0]       rdata
);
  localparam logic [ADDR_W-1:0] ADDR_CFG  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_DATA = ADDR_W'(1);
  localparam int CFG_W = $bits(crcCfg_t);

  always_comb begin
    strobe.loadSeed = wrEn && addr == ADDR_CFG;
    strobe.seedWide = wdata[0];
    strobe.absorb   = wrEn && addr == ADDR_DATA;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cfgReg <= '0;
    else if (strobe.loadSeed) cfgReg <= wdata[CFG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rdEn) begin
      if (addr == ADDR_CFG)       rdata <= {{(32-CFG_W){1'b0}}, cfgReg};
      else if (addr == ADDR_DATA) rdata <= result;
      else                        rdata <= '0;
    end
  end

  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.loadSeed, strobe.absorb}));

  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rdEn |=> $stable(rdata));

  p_narrow_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && !wrEn && addr == ADDR_DATA && !cfgReg.wideSel) |=> rdata[31:16] == 16'h0);
endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);
  crcStrobe_t  strobe;
  crcCfg_t     cfgReg;
  logic [31:0] result;

  crc_control #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .result(result), .strobe(strobe), .cfgReg(cfgReg),
    .rdata(rdata)
  );

  crc_datapath #(.WORD_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .cfg(cfgReg),
    .dataIn(wdata), .result(result)
  );
endmodule

// File: tb/crc_engine_test.sv
`timescale 1ns/100ps
module crc_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  logic [31:0] mState;
  logic [4:0]  mCfg;

  always #2.5 clk = ~clk;

  crc_engine uut (.clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn),
                  .addr(addr), .wdata(wdata), .rdata(rdata));

  // reference model: serial, one bit per step
  task automatic mSeed(input logic [4:0] c);
    mCfg   = c;
    mState = c[0] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endtask

  task automatic mByte(input logic [7:0] b);
    logic [7:0] v;
    logic       top;
    v = b;
    if (mCfg[1]) for (int i = 0; i < 8; i++) v[i] = b[7-i];
    for (int i = 7; i >= 0; i--) begin
      if (mCfg[0]) begin
        top = mState[31] ^ v[i];
        mState = {mState[30:0], 1'b0};
        if (top) mState = mState ^ 32'h04C1_1DB7;
      end else begin
        top = mState[15] ^ v[i];
        mState = {16'h0, mState[14:0], 1'b0};
        if (top) mState = mState ^ 32'h0000_1021;
      end
    end
  endtask

  function automatic logic [31:0] mResult();
    logic [31:0] r;
    int w;
    w = mCfg[0] ? 32 : 16;
    r = mState;
    if (mCfg[2]) begin
      r = '0;
      for (int i = 0; i < w; i++) r[i] = mState[w-1-i];
    end
    if (mCfg[3]) r = r ^ (mCfg[0] ? 32'hFFFF_FFFF : 32'h0000_FFFF);
    return r;
  endfunction

  // driver
  task automatic doWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; rdEn = 1'b0; addr = a; wdata = d;
  endtask

  task automatic doRead(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b1; addr = a; wdata = 32'hDEAD_BEEF;
    expQ.push_back(exp);
    tagQ.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  task automatic wrCfg(input logic [31:0] c);
    doWrite(2'd0, c);
    mSeed(c[4:0]);
  endtask

  task automatic wrByte(input logic [7:0] b);
    doWrite(2'd1, {24'hA5C3E1, b});  // upper bits must be ignored (R6)
    mByte(b);
  endtask

  task automatic wrWord(input logic [31:0] w);
    doWrite(2'd1, w);
    for (int k = 3; k >= 0; k--) mByte(w[k*8 +: 8]);
  endtask

  task automatic feedDigits();
    for (int k = 1; k <= 9; k++) wrByte(8'h30 + 8'(k));
  endtask

  // monitor
  initial begin
    bit pend;
    logic [31:0] e;
    string t;
    forever begin
      @(posedge clk);
      pend = rdEn;
      @(negedge clk);
      if (pend && expQ.size() > 0) begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s: got %08h expected %08h", t, rdata, e);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    mSeed(5'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    doRead(2'd0, 32'h0, "R1 cfg after reset");
    doRead(2'd1, 32'h0000_FFFF, "R1 result after reset");

    wrCfg(32'hFFFF_FFE1);
    doRead(2'd0, 32'h0000_0001, "R2 cfg upper bits dropped");
    doRead(2'd1, 32'hFFFF_FFFF, "R3 wide seed");

    wrCfg(32'h0000_0010);
    doRead(2'd0, 32'h0000_0010, "R2 cfg byte mode");
    doRead(2'd1, 32'h0000_FFFF, "R3 narrow seed");

    feedDigits();
    doRead(2'd1, 32'h0000_29B1, "R4 check string narrow");
    doRead(2'd1, 32'h0000_29B1, "R9 repeated read");
    doWrite(2'd2, 32'h0000_0055);
    doWrite(2'd3, 32'hFFFF_FFFF);
    doRead(2'd1, 32'h0000_29B1, "R9 write to unused address");
    doRead(2'd2, 32'h0, "R9 unused address read");
    doRead(2'd3, 32'h0, "R9 unused address read");
    doRead(2'd0, 32'h0000_0010, "R9 cfg untouched");

    wrCfg(32'h0000_001F);
    feedDigits();
    doRead(2'd1, 32'hCBF4_3926, "R5 check string wide reflected");

    wrCfg(32'h0000_0000);
    wrWord(32'h3132_3334);
    doRead(2'd1, mResult(), "R8 read right after word write");
    wrWord(32'h3536_3738);
    doRead(2'd1, mResult(), "R6 narrow word mode");
    doRead(2'd1, mResult(), "R7 narrow upper zero");

    wrCfg(32'h0000_0010);
    for (int k = 1; k <= 8; k++) wrByte(8'h30 + 8'(k));
    doRead(2'd1, mResult(), "R6 bytes match words");

    wrCfg(32'h0000_000F);
    wrWord(32'h3132_3334);
    wrWord(32'h3536_3738);
    wrWord(32'hFEDC_BA98);
    doRead(2'd1, mResult(), "R6 wide word mode back-to-back");

    wrCfg(32'h0000_001E);
    feedDigits();
    doRead(2'd1, mResult(), "R7 narrow reflected inverted");

    wrCfg(32'h0000_0011);
    feedDigits();
    doRead(2'd1, mResult(), "R5 wide plain");
    idle();
    idle();
    doRead(2'd1, mResult(), "R8 result held while idle");
    idle();
    idle();
    idle();

    finished = 1'b1;
    if (expQ.size() != 0) begin
      errors++; checks++;
      $display("FAIL R8: got %0d pending reads expected 0", expQ.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule